// File: doc/BRIEF.md
# Nibble-Granular Flash Program Engine

This block is the self-timed write engine behind a page program command of a serial flash. It stores a behavioural byte array. A command layer, which sits outside this block, hands it a complete page of data with one valid bit per byte, a page index and a start pulse. The engine then steps through every byte offset of the page. For each valid byte it reads the current array contents, applies the program rule to each 4-bit nibble, and writes the result back. A countdown then models the cell programming time. The countdown is shorter when at most one byte is valid.

The program rule follows the physics of a nibble-wide cell group. The erased state is logic 1, and programming can only clear bits. A nibble accepts new data only while all four of its bits are still erased. Asking a partly programmed nibble to clear further bits gives an undefined outcome. The engine writes a fixed scramble pattern into such a nibble, sets a sticky integrity flag and records the address of the first corrupted byte. A write-enable latch must be set before the engine accepts a start, and the engine clears that latch when the operation completes. A block-erase input refills one block of the array with FFh so that tests can return the array to the erased state. A direct read port exposes the array for checking.

Top module: `flash_prog_engine`

## Requirements
- R1: After reset, busy_o, wel_o and err_o are 0, err_addr_o is 0, and every array byte reads FFh.
- R2: A start_i pulse is accepted only when wel_o is 1 and busy_o is 0. A start with wel_o at 0 leaves busy_o at 0 and changes no byte of the array.
- R3: After an accepted start, busy_o stays high for exactly PAGE_BYTES + T_BYTE cycles when at most one bit of buf_valid_i is set, and for PAGE_BYTES + T_PAGE cycles otherwise.
- R4: wel_set_i sets wel_o in the next cycle. The engine clears wel_o in the cycle it completes, and a wel_set_i that arrives at that same completion edge is lost.
- R5: A start_i pulse while busy_o is high is ignored. The page it names stays unchanged, and the running operation keeps its own length and data.
- R6: Byte i of the page lives in buf_data_i[8i+7:8i], and its valid bit is buf_valid_i[i]. It is written to array address page_i*PAGE_BYTES + i. Bytes whose valid bit is 0 are left untouched.
- R7: For each nibble, a fully erased old value (4'hF) takes the new value. A nibble whose new data clears no bit that is still 1 keeps its old value and raises no flag.
- R8: A nibble that would clear a bit that is still 1 while some bit of it is already 0 is written as (old AND new) XOR 4'b0101. err_o becomes 1 and stays 1 until reset, and err_addr_o holds the address of the first such byte.
- R9: erase_i with busy_o low sets every byte of block erase_blk_i (BLOCK_BYTES bytes, aligned) to FFh. erase_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a page program |
| page_i | input | ADDR_W-log2(PAGE_BYTES) | Target page index |
| buf_data_i | input | PAGE_BYTES*8 | Committed page buffer, byte i at bits 8i+7:8i |
| buf_valid_i | input | PAGE_BYTES | Per-byte valid mask |
| wel_set_i | input | 1 | Sets the write-enable latch |
| erase_i | input | 1 | Block erase request |
| erase_blk_i | input | ADDR_W-log2(BLOCK_BYTES) | Block index to erase |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array byte at rd_addr_i (combinational) |
| busy_o | output | 1 | Operation in progress |
| wel_o | output | 1 | Write-enable latch |
| err_o | output | 1 | Sticky nibble integrity error |
| err_addr_o | output | ADDR_W | Address of the first corrupted byte |

## Verification
Two events can land on the same edge: the completion that clears the write-enable latch, and a wel_set_i request. The bench counts cycles from an accepted start and raises wel_set_i exactly on the completion edge. It then expects wel_o to read 0, and a second set one cycle later to take effect. A start pulse or an erase request issued in the middle of a running operation also collides with the engine. The scoreboard judges both by reading back the target page and the erased block afterwards.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_HOLD} prog_state_e;
  localparam logic [7:0] ERASED_BYTE  = 8'hFF;
  localparam logic [3:0] NIB_SCRAMBLE = 4'b0101;
endpackage

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
  import flash_prog_pkg::*;
(
  input  logic [7:0] old_i,
  input  logic [7:0] new_i,
  output logic [7:0] res_o,
  output logic       undef_o
);
  logic [1:0] nib_undef;

  for (genvar g = 0; g < 2; g++) begin : g_nib
    logic [3:0] o_n, n_n, clr;
    assign o_n = old_i[4*g +: 4];
    assign n_n = new_i[4*g +: 4];
    assign clr = o_n & ~n_n;
    always_comb begin
      nib_undef[g] = 1'b0;
      if (clr == 4'h0)        res_o[4*g +: 4] = o_n;
      else if (o_n == 4'hF)   res_o[4*g +: 4] = n_n;
      else begin
        res_o[4*g +: 4] = (o_n & n_n) ^ NIB_SCRAMBLE;
        nib_undef[g]    = 1'b1;
      end
    end
  end

  assign undef_o = |nib_undef;

  always_comb begin
    if (!undef_o && !$isunknown({old_i, new_i}))
      AST_NO_SET_BITS: assert ((res_o & ~old_i) == 8'h00); // R7
  end
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BLOCK_BYTES = 64,
  localparam int DEPTH      = 1 << ADDR_W,
  localparam int BLK_SHIFT  = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = ADDR_W - BLK_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [7:0]        rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [7:0]        rdata_b_o,
  input  logic              erase_i,
  input  logic [BLK_W-1:0]  erase_blk_i
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_i && ((i >> BLK_SHIFT) == int'(erase_blk_i))) mem_q[i] <= ERASED_BYTE;
      end
      if (we_i) mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  AST_ERASE_WRITE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_i && we_i)); // R9
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int T_BYTE     = 8,
  parameter int T_PAGE     = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W,
  localparam int T_MAX     = (T_PAGE > T_BYTE) ? T_PAGE : T_BYTE,
  localparam int TMR_W     = $clog2(T_MAX + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    wel_set_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [PAGE_BYTES-1:0]   valid_i,
  output logic                    busy_o,
  output logic                    wel_o,
  output logic                    err_o,
  output logic [ADDR_W-1:0]       err_addr_o,
  output logic [ADDR_W-1:0]       arr_addr_o,
  output logic [7:0]              new_byte_o,
  input  logic [7:0]              prog_res_i,
  input  logic                    prog_undef_i,
  output logic                    arr_we_o,
  output logic [7:0]              arr_wdata_o
);
  prog_state_e             state_q;
  logic [PAGE_BYTES*8-1:0] data_q;
  logic [PAGE_BYTES-1:0]   valid_q;
  logic [PAGE_W-1:0]       page_q;
  logic [OFF_W-1:0]        idx_q;
  logic [TMR_W-1:0]        tmr_q;
  logic                    wel_q, err_q;
  logic [ADDR_W-1:0]       err_addr_q;
  logic                    accept, done, cur_valid, few;

  assign busy_o     = (state_q != ST_IDLE);
  assign accept     = start_i && !busy_o && wel_q;
  assign done       = (state_q == ST_HOLD) && (tmr_q == '0);
  assign few        = ($countones(valid_i) < 2);
  assign arr_addr_o = {page_q, idx_q};
  assign new_byte_o = data_q[{idx_q, 3'b000} +: 8];
  assign cur_valid  = valid_q[idx_q];
  assign arr_we_o   = (state_q == ST_WALK) && cur_valid;
  assign arr_wdata_o = prog_res_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      valid_q <= '0;
      page_q  <= '0;
      idx_q   <= '0;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_WALK;
          data_q  <= data_i;
          valid_q <= valid_i;
          page_q  <= page_i;
          idx_q   <= '0;
          tmr_q   <= few ? TMR_W'(T_BYTE - 1) : TMR_W'(T_PAGE - 1);
        end
        ST_WALK: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == OFF_W'(PAGE_BYTES - 1)) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_q == '0) state_q <= ST_IDLE;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // completion clear has priority over a coincident set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wel_q <= 1'b0;
    else if (done)      wel_q <= 1'b0;
    else if (wel_set_i) wel_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else if (arr_we_o && prog_undef_i && !err_q) begin
      err_q      <= 1'b1;
      err_addr_q <= arr_addr_o;
    end
  end

  assign wel_o      = wel_q;
  assign err_o      = err_q;
  assign err_addr_o = err_addr_q;

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wel_q)); // R2
  AST_WEL_CLR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !wel_q); // R4
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(page_q)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R8
  AST_ERR_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && $past(err_q)) |-> $stable(err_addr_q)); // R8
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int BLOCK_BYTES = 64,
  parameter int T_BYTE      = 8,
  parameter int T_PAGE      = 40,
  localparam int PAGE_W     = ADDR_W - $clog2(PAGE_BYTES),
  localparam int BLK_W      = ADDR_W - $clog2(BLOCK_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [PAGE_BYTES*8-1:0] buf_data_i,
  input  logic [PAGE_BYTES-1:0]   buf_valid_i,
  input  logic                    wel_set_i,
  input  logic                    erase_i,
  input  logic [BLK_W-1:0]        erase_blk_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o,
  output logic                    busy_o,
  output logic                    wel_o,
  output logic                    err_o,
  output logic [ADDR_W-1:0]       err_addr_o
);
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0]        old_byte, new_byte, res_byte, wdata;
  logic              undef, we, erase_en;

  assign erase_en = erase_i && !busy_o;

  flash_prog_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .T_BYTE(T_BYTE), .T_PAGE(T_PAGE)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .wel_set_i,
    .page_i, .data_i(buf_data_i), .valid_i(buf_valid_i),
    .busy_o, .wel_o, .err_o, .err_addr_o,
    .arr_addr_o(arr_addr), .new_byte_o(new_byte),
    .prog_res_i(res_byte), .prog_undef_i(undef),
    .arr_we_o(we), .arr_wdata_o(wdata)
  );

  flash_byte_prog u_prog (
    .old_i(old_byte), .new_i(new_byte), .res_o(res_byte), .undef_o(undef)
  );

  flash_array #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_array (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(arr_addr), .wdata_i(wdata),
    .raddr_a_i(arr_addr), .rdata_a_o(old_byte),
    .raddr_b_i(rd_addr_i), .rdata_b_o(rd_data_o),
    .erase_i(erase_en), .erase_blk_i
  );
endmodule

// File: tb/flash_prog_engine_tb_top.sv
module flash_prog_engine_tb_top;
  localparam int P  = 16;
  localparam int TB = 8;
  localparam int TP = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, wel_set = 1'b0, erase = 1'b0;
  logic [3:0]    page = '0;
  logic [127:0]  buf_data = '0;
  logic [15:0]   buf_valid = '0;
  logic [1:0]    erase_blk = '0;
  logic [7:0]    rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy, wel, err;
  logic [7:0]    err_addr;

  always #2.5 clk = ~clk;

  flash_prog_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_i(page),
    .buf_data_i(buf_data), .buf_valid_i(buf_valid), .wel_set_i(wel_set),
    .erase_i(erase), .erase_blk_i(erase_blk), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .wel_o(wel), .err_o(err),
    .err_addr_o(err_addr)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] shadow [256];
  logic       m_err = 1'b0;
  logic [7:0] m_err_addr = '0;

  logic [7:0] q_addr [$];
  logic [7:0] q_data [$];
  string      q_tag  [$];
  int         pushed = 0, compared = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // scoreboard monitor: owns rd_addr
  initial begin
    forever begin
      logic [7:0] a, d;
      string t;
      wait (q_addr.size() > 0);
      a = q_addr.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
      rd_addr = a;
      @(negedge clk);
      chk(t, rd_data, d);
      compared++;
    end
  end

  task automatic expect_page(input logic [3:0] pg, input string tag);
    for (int i = 0; i < P; i++) begin
      q_addr.push_back({pg, 4'(i)});
      q_data.push_back(shadow[{pg, 4'(i)}]);
      q_tag.push_back(tag);
      pushed++;
    end
    wait (compared == pushed);
  endtask

  // reference nibble rule taken from R7/R8
  function automatic logic [4:0] ref_nib(input logic [3:0] o, input logic [3:0] n);
    if ((o & ~n) == 4'h0) return {1'b0, o};
    if (o == 4'hF)        return {1'b0, n};
    return {1'b1, (o & n) ^ 4'b0101};
  endfunction

  task automatic model_prog(input logic [3:0] pg, input logic [127:0] dat, input logic [15:0] vld);
    for (int i = 0; i < P; i++) begin
      if (vld[i]) begin
        logic [7:0] a;
        logic [4:0] hi, lo;
        a  = {pg, 4'(i)};
        hi = ref_nib(shadow[a][7:4], dat[8*i+4 +: 4]);
        lo = ref_nib(shadow[a][3:0], dat[8*i +: 4]);
        shadow[a] = {hi[3:0], lo[3:0]};
        if ((hi[4] || lo[4]) && !m_err) begin
          m_err = 1'b1; m_err_addr = a;
        end
      end
    end
  endtask

  task automatic kick(input logic [3:0] pg, input logic [127:0] dat, input logic [15:0] vld);
    @(negedge clk);
    page = pg; buf_data = dat; buf_valid = vld; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic set_wel();
    @(negedge clk); wel_set = 1'b1;
    @(negedge clk); wel_set = 1'b0;
  endtask

  task automatic do_erase(input logic [1:0] blk);
    @(negedge clk); erase = 1'b1; erase_blk = blk;
    if (!busy) for (int i = 0; i < 64; i++) shadow[{blk, 6'(i)}] = 8'hFF;
    @(negedge clk); erase = 1'b0;
  endtask

  function automatic logic [127:0] put(input logic [127:0] d, input int i, input logic [7:0] b);
    logic [127:0] r = d;
    r[8*i +: 8] = b;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int cyc;
    logic [127:0] d;
    for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 wel", wel, 0);
    chk("R1 err", err, 0);
    chk("R1 err_addr", err_addr, 0);
    expect_page(4'h2, "R1 erased array");

    // R2 start without write enable
    kick(4'h2, put('0, 3, 8'h00), 16'h0008);
    chk("R2 busy without wel", busy, 0);
    repeat (3) @(negedge clk);
    chk("R2 busy stays low", busy, 0);
    expect_page(4'h2, "R2 array untouched");

    // R4 set, R3 single-byte length, R6 erased nibbles and mapping
    set_wel();
    chk("R4 wel set", wel, 1);
    d = put({16{8'h11}}, 5, 8'h7F);
    kick(4'h2, d, 16'h0020);
    wait_idle(cyc);
    model_prog(4'h2, d, 16'h0020);
    chk("R3 single byte busy cycles", cyc, P + TB);
    chk("R4 wel cleared at completion", wel, 0);
    expect_page(4'h2, "R6 single byte and untouched bytes");

    // R7 no-op nibble and erased nibble, R3 page length
    set_wel();
    d = put(put(put('0, 0, 8'h00), 5, 8'hFC), 15, 8'hA5);
    kick(4'h2, d, 16'h8021);
    wait_idle(cyc);
    model_prog(4'h2, d, 16'h8021);
    chk("R3 page busy cycles", cyc, P + TP);
    chk("R7 no flag", err, 0);
    expect_page(4'h2, "R7 7F then FC");

    // R5 start while busy
    set_wel();
    d = put('0, 1, 8'h3C);
    kick(4'h3, d, 16'h0002);
    repeat (4) @(negedge clk);
    start = 1'b1; page = 4'h4; buf_data = '0; buf_valid = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    wait_idle(cyc);
    model_prog(4'h3, d, 16'h0002);
    chk("R5 running length kept", cyc + 5, P + TB);
    expect_page(4'h4, "R5 ignored start page");
    expect_page(4'h3, "R5 running op data");

    // R8 undefined nibble, first address
    set_wel();
    d = put('0, 5, 8'hBF);
    kick(4'h2, d, 16'h0020);
    wait_idle(cyc);
    model_prog(4'h2, d, 16'h0020);
    chk("R8 err set", err, 1);
    chk("R8 err_addr", err_addr, 8'h25);
    expect_page(4'h2, "R8 scramble 7C then BF");
    set_wel();
    d = put('0, 15, 8'h5A);
    kick(4'h2, d, 16'h8000);
    wait_idle(cyc);
    model_prog(4'h2, d, 16'h8000);
    chk("R8 err sticky", err, 1);
    chk("R8 err_addr keeps first", err_addr, m_err_addr);
    expect_page(4'h2, "R8 second scramble");

    // R9 erase ignored while busy, then applied when idle
    set_wel();
    d = put('0, 2, 8'h0F);
    kick(4'h1, d, 16'h0004);
    do_erase(2'd0);
    wait_idle(cyc);
    model_prog(4'h1, d, 16'h0004);
    expect_page(4'h2, "R9 erase while busy ignored");
    expect_page(4'h1, "R9 op beside busy erase");
    do_erase(2'd0);
    expect_page(4'h2, "R9 idle erase page2");
    expect_page(4'h1, "R9 idle erase page1");
    expect_page(4'h4, "R9 other block untouched");

    // R4 wel set on the completion edge is lost
    set_wel();
    d = put('0, 9, 8'hF0);
    kick(4'h5, d, 16'h0200);
    repeat (P + TB - 1) @(negedge clk);
    wel_set = 1'b1;
    @(negedge clk);
    wel_set = 1'b0;
    model_prog(4'h5, d, 16'h0200);
    chk("R4 completion busy low", busy, 0);
    chk("R4 coincident set lost", wel, 0);
    set_wel();
    chk("R4 later set taken", wel, 1);
    expect_page(4'h5, "R6 page5 program");

    summary();
  end
endmodule